// File: doc/BRIEF.md
# Buffered SPI Target with Overrun Detection

This block is the target (slave) end of an SPI link. An external controller supplies the serial clock, so the bit rate follows that clock and no internal clock generator is involved. The serial clock, the data-in line and the active-low select are brought into the system clock domain through multi-stage synchronizers. Edges are then found by comparing each synchronized sample with the previous one. The serial clock must run no faster than a quarter of the system clock.

The block uses one fixed clock mode. The data-out line changes on the falling serial clock edge, and the data-in line is sampled on the rising edge. Software writes a character into a single-entry transmit holding register through a write strobe. That character moves into the transmit shift register only while no character is in progress, so it goes out only if it was moved there before the controller's first rising edge. Each completed character lands in a single-entry receive register. Software takes it with a read strobe. A sticky overrun flag records a received character that replaced one software had not yet read. Characters are 7 or 8 bits long and can be shifted most-significant bit first or least-significant bit first.

Top module: `spi_tgt_buffered`

## Requirements
- R1: After reset, tx_empty_o is 1, rx_ready_o is 0, overrun_o is 0, rx_data_o is 0x00 and miso_oe_o is 0.
- R2: The character length is 8 bits when len7_i is 0 and 7 bits when it is 1. When msb_first_i is 1, miso_o shows bit 7 (bit 6 in 7-bit mode) before the first rising serial clock edge and then each lower bit after each falling edge. When msb_first_i is 0, it starts with bit 0 and moves upward.
- R3: mosi_i is sampled on rising serial clock edges. After the configured number of bits, the character is placed in rx_data_o with rx_ready_o set to 1. The first bit received is the top bit of the character when msb_first_i is 1 and bit 0 when it is 0. In 7-bit mode the data sits in bits 6..0 and bit 7 reads 0.
- R4: A tx_wr_i pulse makes tx_empty_o 0. The held character moves to the shift register only while the bit count is zero, and tx_empty_o returns to 1 at that move. A second write while a character is held keeps tx_empty_o at 0 until the next move.
- R5: A character that starts with no character moved into the shift register sends all zeros on miso_o.
- R6: An rx_rd_i pulse with no delivery in the same cycle clears rx_ready_o.
- R7: overrun_o is set when a character is delivered while rx_ready_o is 1 and no read happens in that cycle. It then stays set, through reads, until an overrun_clr_i pulse. If a set and a clear fall in the same cycle, the set wins.
- R8: When a read and a delivery fall in the same cycle, overrun_o stays 0, rx_ready_o stays 1 and rx_data_o shows the new character.
- R9: While cs_n_i is high (inactive), miso_oe_o is 0, serial clock edges are ignored and the bit count is held at zero. A character cut short by deselection is discarded on both sides, and its transmit data is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the controller |
| mosi_i | input | 1 | Serial data from the controller |
| cs_n_i | input | 1 | Active-low target select |
| miso_o | output | 1 | Serial data to the controller |
| miso_oe_o | output | 1 | Output enable for miso_o (pad tristate control) |
| len7_i | input | 1 | 1 selects 7-bit characters, 0 selects 8-bit |
| msb_first_i | input | 1 | 1 shifts the top bit first, 0 shifts bit 0 first |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | DATA_W | Character to transmit |
| rx_rd_i | input | 1 | Read strobe acknowledging rx_data_o |
| rx_data_o | output | DATA_W | Last received character |
| rx_ready_o | output | 1 | Unread received character present |
| tx_empty_o | output | 1 | Transmit holding register can take a character |
| overrun_o | output | 1 | Sticky overrun flag |
| overrun_clr_i | input | 1 | Clears overrun_o |

## Verification
Two functions can land in the same system clock cycle. One is the delivery of a finished character into the receive register. The other is a software read of the previous character. The bench times an rx_rd_i pulse to the cycle in which the synchronized final rising edge is acted on, which is two system clocks after that serial clock edge is driven. It then expects rx_ready_o to stay 1, the new character to be visible and overrun_o to stay 0. A second pair is a transmit write arriving while the previous character is still held: the bench checks that tx_empty_o stays 0 and that both characters go out in order.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

   // Per-character framing options sampled by the shift engine
   typedef struct packed {
      logic len_short;   // 1: one bit shorter than DATA_W
      logic msb_first;   // 1: top bit leaves/arrives first
   } spi_tgt_cfg_t;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
   parameter int         W       = 3,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_tgt_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter
   import spi_tgt_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              sel_i,
   input  logic              mosi_i,
   input  spi_tgt_cfg_t      cfg_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_data_i,
   output logic              load_ok_o,
   output logic              miso_o,
   output logic              deliver_o,
   output logic [DATA_W-1:0] deliver_word_o
);

   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] rx_next;
   logic              sh_empty;
   logic [CNT_W-1:0]  last_idx;
   logic              cnt_zero;

   assign last_idx = cfg_i.len_short ? LAST_SHORT : LAST_LONG;
   assign cnt_zero = (bit_cnt == '0);

   // Receive shift: new bit enters at the low end (top-first) or at the
   // top of the active length (bit-0-first)
   always_comb begin
      if (cfg_i.msb_first)
         rx_next = {rx_sh[DATA_W-2:0], mosi_i};
      else if (cfg_i.len_short)
         rx_next = {1'b0, mosi_i, rx_sh[DATA_W-2:1]};
      else
         rx_next = {mosi_i, rx_sh[DATA_W-1:1]};
   end

   always_comb begin
      deliver_word_o = rx_next;
      if (cfg_i.len_short) deliver_word_o[DATA_W-1] = 1'b0;
   end

   assign deliver_o = sel_i && rise_i && (bit_cnt == last_idx);
   assign load_ok_o = sh_empty && cnt_zero && !(sel_i && rise_i);

   always_comb begin
      if (!cfg_i.msb_first)      miso_o = tx_sh[0];
      else if (cfg_i.len_short)  miso_o = tx_sh[DATA_W-2];
      else                       miso_o = tx_sh[DATA_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         sh_empty <= 1'b1;
      end else begin
         if (!sel_i) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            if (!cnt_zero) begin
               sh_empty <= 1'b1;
               tx_sh    <= '0;
            end
         end else if (rise_i) begin
            if (deliver_o) begin
               bit_cnt  <= '0;
               rx_sh    <= '0;
               sh_empty <= 1'b1;
               tx_sh    <= '0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
               rx_sh   <= rx_next;
            end
         end else if (fall_i && !cnt_zero) begin
            if (cfg_i.msb_first) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            else                 tx_sh <= {1'b0, tx_sh[DATA_W-1:1]};
         end
         if (load_i) begin
            tx_sh    <= load_data_i;
            sh_empty <= 1'b0;
         end
      end
   end

   AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_i && !cnt_zero) |=> (sh_empty && cnt_zero)) else $error("abort"); // R9

   AST_DELIVER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      deliver_o |=> (cnt_zero && sh_empty)) else $error("restart"); // R3

   AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_zero && !sh_empty)) else $error("load"); // R4

endmodule

// File: rtl/spi_tgt_bufs.sv
module spi_tgt_bufs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_wr_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              rx_rd_i,
   input  logic              ovr_clr_i,
   input  logic              load_ok_i,
   input  logic              deliver_i,
   input  logic [DATA_W-1:0] deliver_word_i,
   output logic              load_o,
   output logic [DATA_W-1:0] load_data_o,
   output logic              tx_empty_o,
   output logic              rx_ready_o,
   output logic              overrun_o,
   output logic [DATA_W-1:0] rx_data_o
);

   logic              tx_full;
   logic [DATA_W-1:0] tx_hold;

   assign load_o      = tx_full && load_ok_i;
   assign load_data_o = tx_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_full    <= 1'b0;
         tx_hold    <= '0;
         tx_empty_o <= 1'b1;
      end else if (tx_wr_i) begin
         tx_hold    <= tx_data_i;
         tx_full    <= 1'b1;
         tx_empty_o <= 1'b0;
      end else if (load_o) begin
         tx_full    <= 1'b0;
         tx_empty_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data_o  <= '0;
         rx_ready_o <= 1'b0;
         overrun_o  <= 1'b0;
      end else begin
         if (deliver_i) begin
            rx_data_o  <= deliver_word_i;
            rx_ready_o <= 1'b1;
         end else if (rx_rd_i) begin
            rx_ready_o <= 1'b0;
         end
         if (deliver_i && rx_ready_o && !rx_rd_i) overrun_o <= 1'b1;
         else if (ovr_clr_i)                      overrun_o <= 1'b0;
      end
   end

   AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr_i |=> !tx_empty_o) else $error("wr"); // R4

   AST_RDY_ON_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
      deliver_i |=> rx_ready_o) else $error("rdy"); // R3

   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd_i && !deliver_i) |=> !rx_ready_o) else $error("rd"); // R6

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_o && !ovr_clr_i) |=> overrun_o) else $error("sticky"); // R7

   AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver_i && rx_rd_i && !overrun_o) |=> (!overrun_o && rx_ready_o)) else $error("same"); // R8

endmodule

// File: rtl/spi_tgt_buffered.sv
module spi_tgt_buffered
   import spi_tgt_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit USE_CS      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              mosi_i,
   input  logic              cs_n_i,
   output logic              miso_o,
   output logic              miso_oe_o,
   input  logic              len7_i,
   input  logic              msb_first_i,
   input  logic              tx_wr_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              rx_rd_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_ready_o,
   output logic              tx_empty_o,
   output logic              overrun_o,
   input  logic              overrun_clr_i
);

   if (DATA_W < 3) begin : g_bad_width
      $error("spi_tgt_buffered: DATA_W must be at least 3");
   end

   logic [2:0]        pins_s;
   logic              sclk_s, mosi_s, cs_n_s;
   logic              sclk_q;
   logic              sel;
   logic              rise, fall;
   logic              load, load_ok, deliver;
   logic [DATA_W-1:0] load_data, deliver_word;
   spi_tgt_cfg_t      cfg;

   spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_n_i, mosi_i, sclk_i}),
      .q_o   (pins_s)
   );

   assign {cs_n_s, mosi_s, sclk_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   assign rise = sclk_s && !sclk_q;
   assign fall = !sclk_s && sclk_q;

   if (USE_CS) begin : g_select
      assign sel       = !cs_n_s;
      assign miso_oe_o = !cs_n_s;
   end else begin : g_no_select
      assign sel       = 1'b1;
      assign miso_oe_o = 1'b1;
   end

   assign cfg.len_short = len7_i;
   assign cfg.msb_first = msb_first_i;

   spi_tgt_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk            (clk),
      .rst_n          (rst_n),
      .rise_i         (rise),
      .fall_i         (fall),
      .sel_i          (sel),
      .mosi_i         (mosi_s),
      .cfg_i          (cfg),
      .load_i         (load),
      .load_data_i    (load_data),
      .load_ok_o      (load_ok),
      .miso_o         (miso_o),
      .deliver_o      (deliver),
      .deliver_word_o (deliver_word)
   );

   spi_tgt_bufs #(.DATA_W(DATA_W)) u_bufs (
      .clk            (clk),
      .rst_n          (rst_n),
      .tx_wr_i        (tx_wr_i),
      .tx_data_i      (tx_data_i),
      .rx_rd_i        (rx_rd_i),
      .ovr_clr_i      (overrun_clr_i),
      .load_ok_i      (load_ok),
      .deliver_i      (deliver),
      .deliver_word_i (deliver_word),
      .load_o         (load),
      .load_data_o    (load_data),
      .tx_empty_o     (tx_empty_o),
      .rx_ready_o     (rx_ready_o),
      .overrun_o      (overrun_o),
      .rx_data_o      (rx_data_o)
   );

   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> !deliver) else $error("desel"); // R9

endmodule

// File: tb/spi_tgt_buffered_test.sv
`timescale 1ns/1ps
module spi_tgt_buffered_test;

   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
   logic       miso, miso_oe;
   logic       len7 = 1'b0, msbf = 1'b1;
   logic       tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic [7:0] rx_data;
   logic       rx_ready, tx_empty, overrun;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   spi_tgt_buffered uut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .cs_n_i(cs_n),
      .miso_o(miso), .miso_oe_o(miso_oe), .len7_i(len7), .msb_first_i(msbf),
      .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd),
      .rx_data_o(rx_data), .rx_ready_o(rx_ready), .tx_empty_o(tx_empty),
      .overrun_o(overrun), .overrun_clr_i(ovr_clr)
   );

   // {len7, msb_first, tx character, mosi character}
   localparam logic [17:0] VEC [0:5] = '{
      {1'b0, 1'b1, 8'hA5, 8'h3C},
      {1'b0, 1'b0, 8'h81, 8'hC2},
      {1'b1, 1'b1, 8'h55, 8'h7E},
      {1'b1, 1'b0, 8'h6B, 8'hFF},
      {1'b0, 1'b1, 8'hFF, 8'h00},
      {1'b1, 1'b1, 8'h80, 8'h80}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_tx(input logic [7:0] d);
      tx_data = d; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
   endtask

   task automatic read_rx();
      rx_rd = 1'b1; tick(1); rx_rd = 1'b0; tick(1);
   endtask

   // One full character with select held low around it; miso captured before each rise
   task automatic xfer(input logic [7:0] mo, input bit rd_last, output logic [7:0] got);
      int n;
      n = len7 ? 7 : 8;
      got = 8'h00;
      cs_n = 1'b0; tick(4);
      for (int i = 0; i < n; i++) begin
         int idx;
         idx = msbf ? (n - 1 - i) : i;
         mosi = mo[idx];
         tick(HALF);
         got[idx] = miso;
         sclk = 1'b1;
         if (rd_last && i == n - 1) begin
            tick(2); rx_rd = 1'b1; tick(1); rx_rd = 1'b0; tick(HALF - 3);
         end else begin
            tick(HALF);
         end
         sclk = 1'b0;
      end
      tick(HALF);
      cs_n = 1'b1; tick(4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual %h expected %h", 8'h00, 8'h01);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] got, mask;
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      chk("R1 tx_empty", {7'd0, tx_empty}, 8'h01);
      chk("R1 rx_ready", {7'd0, rx_ready}, 8'h00);
      chk("R1 overrun", {7'd0, overrun}, 8'h00);
      chk("R1 rx_data", rx_data, 8'h00);
      chk("R1 miso_oe", {7'd0, miso_oe}, 8'h00);

      // Table walk: R2 transmit order/length, R3 receive, R4, R6
      for (int v = 0; v < 6; v++) begin
         len7 = VEC[v][17]; msbf = VEC[v][16];
         mask = len7 ? 8'h7F : 8'hFF;
         tick(2);
         write_tx(VEC[v][15:8]);
         tick(3);
         xfer(VEC[v][7:0], 1'b0, got);
         chk("R2 miso sequence", got, VEC[v][15:8] & mask);
         chk("R3 rx_data", rx_data, VEC[v][7:0] & mask);
         chk("R3 rx_ready", {7'd0, rx_ready}, 8'h01);
         chk("R4 tx_empty after move", {7'd0, tx_empty}, 8'h01);
         read_rx();
         chk("R6 read clears ready", {7'd0, rx_ready}, 8'h00);
      end

      len7 = 1'b0; msbf = 1'b1;
      // R9 select drives output enable
      cs_n = 1'b0; tick(4);
      chk("R9 miso_oe selected", {7'd0, miso_oe}, 8'h01);
      cs_n = 1'b1; tick(4);

      // R5 nothing loaded -> zeros
      xfer(8'h99, 1'b0, got);
      chk("R5 unloaded sends zeros", got, 8'h00);
      read_rx();

      // R4 second write held while first sits in shift register
      write_tx(8'h12); tick(2);
      write_tx(8'h34); tick(2);
      chk("R4 held write keeps empty low", {7'd0, tx_empty}, 8'h00);
      xfer(8'h01, 1'b0, got);
      chk("R4 first held char sent", got, 8'h12);
      chk("R4 empty after second move", {7'd0, tx_empty}, 8'h01);
      xfer(8'h02, 1'b0, got);
      chk("R4 second char sent", got, 8'h34);

      // R7 overrun: rx_ready still set from the 0x01 character
      chk("R7 ready before overrun", {7'd0, rx_ready}, 8'h01);
      chk("R7 overrun set", {7'd0, overrun}, 8'h01);
      chk("R7 newest data kept", rx_data, 8'h02);
      read_rx();
      chk("R7 overrun sticky past read", {7'd0, overrun}, 8'h01);
      ovr_clr = 1'b1; tick(1); ovr_clr = 1'b0; tick(1);
      chk("R7 overrun cleared", {7'd0, overrun}, 8'h00);

      // R8 read lands in the delivery cycle while previous char unread
      xfer(8'h44, 1'b0, got);
      xfer(8'hC3, 1'b1, got);
      chk("R8 no overrun", {7'd0, overrun}, 8'h00);
      chk("R8 ready stays", {7'd0, rx_ready}, 8'h01);
      chk("R8 new data", rx_data, 8'hC3);
      read_rx();

      // R9 abort: three bits then deselect
      write_tx(8'hF0); tick(3);
      cs_n = 1'b0; tick(4);
      for (int i = 0; i < 3; i++) begin
         mosi = 1'b1; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
      end
      tick(HALF);
      cs_n = 1'b1; tick(4);
      chk("R9 oe off when deselected", {7'd0, miso_oe}, 8'h00);
      for (int i = 0; i < 10; i++) begin
         sclk = 1'b1; tick(HALF); sclk = 1'b0; tick(HALF);
      end
      chk("R9 clocks ignored while deselected", {7'd0, rx_ready}, 8'h00);
      xfer(8'h5A, 1'b0, got);
      chk("R9 count restarted", rx_data, 8'h5A);
      chk("R9 aborted tx dropped", got, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule